// File: doc/BRIEF.md
# Serial Frequency-Word Configuration Port

This block takes configuration data in over a three-line serial port (serial clock, serial data and destination control lines) and holds it in a small register bank that feeds a frequency synthesizer. The serial clock is not used as a clock. The system clock samples it, and each observed low-to-high transition moves one bit, least significant bit first, into whichever register the control lines select. There are four registers. The first is a live 20-bit primary shift register. The second is a 20-bit secondary copy, taken from the primary when the store line rises. The third is a 20-bit working register that a nonvolatile store outside the block can load in parallel; it can also be shifted in and out serially. The fourth is an 8-bit mode register, which is staged in a shadow and becomes active only when its write line falls.

Two lines pick one of the three 20-bit words. The chosen word is broken into a 6-bit reference divide value, a 9-bit main divide value, a 4-bit swallow count and a prescaler-bypass flag, and the bit order inside the word is scrambled. The active mode bits request power-down and immediate counter load. They also choose which internal signal goes out on the serial output pin. These functions work only while the active-low enhancement line is held low. The serial port has no valid/ready handshake and cannot apply back-pressure: the block accepts every sampled serial clock transition, so the sender sets the pace.

Top module: `cfg_port_bank`

## Requirements
- R1: Each rising transition of `sclk`, as seen on a system clock edge, shifts the selected register right by one bit and places `sdata` in its top bit. After 20 transitions, the bit sent first sits at word bit 0.
- R2: Destination decode. With `store_wr`=0, `ld_sel`=0 and `mode_wr`=0 the target is the primary register. With `store_wr`=0, `ld_sel`=0 and `mode_wr`=1 the target is the mode shadow. With `store_wr`=0 and `ld_sel`=1 the target is the working register. With `store_wr`=1 nothing shifts. A register that is not the target keeps its value.
- R3: A rising edge on `store_wr` copies the primary register into the secondary register.
- R4: The mode shadow reaches the active mode register only on a falling edge of `mode_wr`. Until that edge, the mode outputs keep their previous values.
- R5: While `enh_n` is 1, all mode functions are inactive: `pwr_down`=0, `cnt_load`=0, `mode_err`=0, and `sout`=0.
- R6: Word selection. `word_sel`=1 picks the working register. `word_sel`=0 with `fsel`=1 picks the primary register, which drives the fields live with no copy step. `word_sel`=0 with `fsel`=0 picks the secondary register.
- R7: Field map, from word bit 0 upward: R5, R4, M8, M7, PB, M6, M5, M4, M3, M2, M1, M0, R3, R2, R1, R0, A3, A2, A1, A0. These feed `r_val`, `m_val`, `a_val` and `bypass`.
- R8: The working register loads `nv_word` in two cases: when `word_sel` rises while `ld_sel`=0, and when `ld_sel` falls while `word_sel`=1.
- R9: When mode bit 1 is active, `sout` shows bit 0 of the working register before any shift. Each serial transition then presents the next bit, and `sdata` enters at the top.
- R10: Mode bit 2 routes `fb_div` to `sout`, bit 5 routes `mod_sel` and bit 6 routes `ref_div`. Bit 3 drives `pwr_down` and bit 4 drives `cnt_load`. Bits 0 and 7 have no function.
- R11: If more than one of mode bits 1, 2, 5 and 6 is active, `sout` follows the lowest-numbered of them and `mode_err` is 1.
- R12: Reset clears every register, including the mode shadow and the active mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, sampled as a level |
| sdata | input | 1 | Serial data, least significant bit first |
| store_wr | input | 1 | Secondary copy strobe and destination control |
| mode_wr | input | 1 | Mode destination select; its falling edge applies the mode |
| ld_sel | input | 1 | Working-register destination and parallel-load control |
| word_sel | input | 1 | Selects the working register as the frequency word |
| fsel | input | 1 | Chooses primary (1) or secondary (0) when word_sel is 0 |
| enh_n | input | 1 | Active-low enable for the mode functions |
| nv_word | input | 20 | Parallel data from the nonvolatile store |
| fb_div | input | 1 | Divided feedback signal, routed to sout |
| mod_sel | input | 1 | Modulus-select signal, routed to sout |
| ref_div | input | 1 | Reference-divider output, routed to sout |
| work_word | output | 20 | Working register contents, for the nonvolatile write |
| r_val | output | 6 | Reference divide field |
| m_val | output | 9 | Main divide field |
| a_val | output | 4 | Swallow count field |
| bypass | output | 1 | Prescaler bypass flag |
| pwr_down | output | 1 | Power-down request |
| cnt_load | output | 1 | Immediate counter load request |
| sout | output | 1 | Serial output |
| mode_err | output | 1 | More than one serial output source is active |

## Verification
The assertions assume that every control input is synchronous to `clk` and stays stable for at least one sample before and after each `sclk` transition. They also assume the control lines never name two destinations within one serial bit. The stimulus meets this: each serial bit takes three clock cycles, all inputs change only on falling clock edges, and the destination lines are set before a burst starts and held until it ends. Parallel loads and mode updates are triggered by control-line edges that come when no serial transition is pending, so no parallel load ever coincides with a shift.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int WORD_W   = 20;
  localparam int MODE_W   = 8;
  localparam int R_W      = 6;
  localparam int M_W      = 9;
  localparam int A_W      = 4;

  // positions of field runs inside the word (behavioural: the map is fixed)
  localparam int POS_R_HI = 0;   // R5,R4
  localparam int POS_M_HI = 2;   // M8,M7
  localparam int POS_PB   = 4;
  localparam int POS_M_LO = 5;   // M6..M0
  localparam int POS_R_LO = 12;  // R3..R0
  localparam int POS_A    = 16;  // A3..A0
  localparam int N_R_HI   = 2;
  localparam int N_M_HI   = 2;
  localparam int N_M_LO   = M_W - N_M_HI;
  localparam int N_R_LO   = R_W - N_R_HI;

  // active mode bit positions
  localparam int MB_WORK  = 1;
  localparam int MB_FB    = 2;
  localparam int MB_PD    = 3;
  localparam int MB_LOAD  = 4;
  localparam int MB_MSEL  = 5;
  localparam int MB_REF   = 6;
  localparam int N_SRC    = 4;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_PRIM = 2'd1,
    DST_MODE = 2'd2,
    DST_WORK = 2'd3
  } dest_e;
endpackage

// File: rtl/cfg_edge_det.sv
module cfg_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = sig & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~sig & prev_q;
    end
  endgenerate
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        q <= '0;
    else if (load_en)  q <= load_val;
    else if (shift_en) q <= {din, q[W-1:1]};
  end

  // R1: new bit lands on top, the rest move one place down
  a_r1_shift_lsb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> (q[W-1] == $past(din)) && (q[W-2:0] == $past(q[W-1:1])));

  // R8: parallel load takes the offered word
  a_r8_parallel_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> q == $past(load_val));

  // R2: idle register holds
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !load_en) |=> $stable(q));
endmodule

// File: rtl/cfg_field_map.sv
module cfg_field_map
  import cfg_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [R_W-1:0]    r_o,
  output logic [M_W-1:0]    m_o,
  output logic [A_W-1:0]    a_o,
  output logic              pb_o
);
  genvar i;
  generate
    for (i = 0; i < N_R_HI; i++) begin : g_rhi
      assign r_o[R_W-1-i] = word[POS_R_HI+i];
    end
    for (i = 0; i < N_R_LO; i++) begin : g_rlo
      assign r_o[N_R_LO-1-i] = word[POS_R_LO+i];
    end
    for (i = 0; i < N_M_HI; i++) begin : g_mhi
      assign m_o[M_W-1-i] = word[POS_M_HI+i];
    end
    for (i = 0; i < N_M_LO; i++) begin : g_mlo
      assign m_o[N_M_LO-1-i] = word[POS_M_LO+i];
    end
    for (i = 0; i < A_W; i++) begin : g_a
      assign a_o[A_W-1-i] = word[POS_A+i];
    end
  endgenerate

  assign pb_o = word[POS_PB];
endmodule

// File: rtl/cfg_mode_ctl.sv
module cfg_mode_ctl
  import cfg_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic din,
  input  logic apply,
  input  logic enh_n,
  input  logic work_lsb,
  input  logic fb_div,
  input  logic mod_sel,
  input  logic ref_div,
  output logic pwr_down,
  output logic cnt_load,
  output logic sout,
  output logic mode_err
);
  // reserved bit 0 drops off the bottom of the shadow; bit 7 is held but unused
  logic [MW-1:1]          shadow_q;
  logic [MB_REF:MB_WORK]  act_q;
  logic [MB_REF:MB_WORK]  eff;
  logic [N_SRC-1:0]       src_en;
  logic [N_SRC-1:0]       src_v;

  always_ff @(posedge clk) begin
    if (!rst_n)        shadow_q <= '0;
    else if (shift_en) shadow_q <= {din, shadow_q[MW-1:2]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     act_q <= '0;
    else if (apply) act_q <= shadow_q[MB_REF:MB_WORK];
  end

  assign eff    = enh_n ? '0 : act_q;
  assign src_en = {eff[MB_REF], eff[MB_MSEL], eff[MB_FB], eff[MB_WORK]};
  assign src_v  = {ref_div, mod_sel, fb_div, work_lsb};

  always_comb begin
    sout = 1'b0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (src_en[k]) sout = src_v[k];
    end
  end

  assign mode_err = ($countones(src_en) > 1);
  assign pwr_down = eff[MB_PD];
  assign cnt_load = eff[MB_LOAD];

  // R4: active mode changes only on the apply edge
  a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(act_q));

  // R5: disabled enhancement line silences every mode function
  a_r5_enh_off: assert property (@(posedge clk) disable iff (!rst_n)
    enh_n |-> (!pwr_down && !cnt_load && !mode_err && !sout));

  // R11: an error flag is never raised with a single source
  a_r11_err_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !$onehot0({act_q[MB_REF], act_q[MB_MSEL], act_q[MB_FB], act_q[MB_WORK]}));
endmodule

// File: rtl/cfg_port_bank.sv
module cfg_port_bank
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              store_wr,
  input  logic              mode_wr,
  input  logic              ld_sel,
  input  logic              word_sel,
  input  logic              fsel,
  input  logic              enh_n,
  input  logic [WORD_W-1:0] nv_word,
  input  logic              fb_div,
  input  logic              mod_sel,
  input  logic              ref_div,
  output logic [WORD_W-1:0] work_word,
  output logic [R_W-1:0]    r_val,
  output logic [M_W-1:0]    m_val,
  output logic [A_W-1:0]    a_val,
  output logic              bypass,
  output logic              pwr_down,
  output logic              cnt_load,
  output logic              sout,
  output logic              mode_err
);
  logic        sclk_rise, store_rise, mode_fall, wsel_rise, ld_fall;
  dest_e       dst;
  logic        sh_prim, sh_mode, sh_work, work_load;
  logic [WORD_W-1:0] prim_q, sec_q, sel_word;

  cfg_edge_det #(.RISING(1'b1)) u_sclk  (.clk(clk), .rst_n(rst_n), .sig(sclk),     .edge_o(sclk_rise));
  cfg_edge_det #(.RISING(1'b1)) u_store (.clk(clk), .rst_n(rst_n), .sig(store_wr), .edge_o(store_rise));
  cfg_edge_det #(.RISING(1'b0)) u_mode  (.clk(clk), .rst_n(rst_n), .sig(mode_wr),  .edge_o(mode_fall));
  cfg_edge_det #(.RISING(1'b1)) u_wsel  (.clk(clk), .rst_n(rst_n), .sig(word_sel), .edge_o(wsel_rise));
  cfg_edge_det #(.RISING(1'b0)) u_ld    (.clk(clk), .rst_n(rst_n), .sig(ld_sel),   .edge_o(ld_fall));

  always_comb begin
    if (store_wr)     dst = DST_NONE;
    else if (ld_sel)  dst = DST_WORK;
    else if (mode_wr) dst = DST_MODE;
    else              dst = DST_PRIM;
  end

  assign sh_prim   = sclk_rise && (dst == DST_PRIM);
  assign sh_mode   = sclk_rise && (dst == DST_MODE);
  assign sh_work   = sclk_rise && (dst == DST_WORK);
  assign work_load = (wsel_rise && !ld_sel) || (ld_fall && word_sel);

  cfg_shift_reg #(.W(WORD_W)) u_prim (
    .clk(clk), .rst_n(rst_n), .shift_en(sh_prim), .din(sdata),
    .load_en(1'b0), .load_val('0), .q(prim_q));

  cfg_shift_reg #(.W(WORD_W)) u_work (
    .clk(clk), .rst_n(rst_n), .shift_en(sh_work), .din(sdata),
    .load_en(work_load), .load_val(nv_word), .q(work_word));

  always_ff @(posedge clk) begin
    if (!rst_n)          sec_q <= '0;
    else if (store_rise) sec_q <= prim_q;
  end

  always_comb begin
    if (word_sel)  sel_word = work_word;
    else if (fsel) sel_word = prim_q;
    else           sel_word = sec_q;
  end

  cfg_field_map u_map (
    .word(sel_word), .r_o(r_val), .m_o(m_val), .a_o(a_val), .pb_o(bypass));

  cfg_mode_ctl #(.MW(MODE_W)) u_mode_ctl (
    .clk(clk), .rst_n(rst_n), .shift_en(sh_mode), .din(sdata),
    .apply(mode_fall), .enh_n(enh_n), .work_lsb(work_word[0]),
    .fb_div(fb_div), .mod_sel(mod_sel), .ref_div(ref_div),
    .pwr_down(pwr_down), .cnt_load(cnt_load), .sout(sout), .mode_err(mode_err));

  // R2: one serial transition never reaches two registers
  a_r2_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sh_prim, sh_mode, sh_work}));

  // R3: store edge copies the primary into the secondary
  a_r3_secondary_copy: assert property (@(posedge clk) disable iff (!rst_n)
    store_rise |=> sec_q == $past(prim_q));

  // R3: secondary holds between store edges
  a_r3_secondary_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !store_rise |=> $stable(sec_q));

  // R2: store line high blocks every serial shift
  a_r2_store_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    store_wr |=> $stable(prim_q));
endmodule

// File: tb/sim_cfg_port_bank.sv
module sim_cfg_port_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 0, sdata = 0, store_wr = 0, mode_wr = 0, ld_sel = 0;
  logic word_sel = 0, fsel = 1, enh_n = 0;
  logic [19:0] nv_word = '0;
  logic fb_div = 0, mod_sel = 0, ref_div = 0;
  logic [19:0] work_word;
  logic [5:0] r_val;
  logic [8:0] m_val;
  logic [3:0] a_val;
  logic bypass, pwr_down, cnt_load, sout, mode_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_port_bank u0 (.*);

  // vector: {r[5:0], m[8:0], a[3:0], pb}
  localparam logic [19:0] VEC [4] = '{
    {6'h3F, 9'h1FF, 4'hF, 1'b1},
    {6'h00, 9'h001, 4'h0, 1'b0},
    {6'h2A, 9'h155, 4'h5, 1'b0},
    {6'h15, 9'h0AA, 4'hA, 1'b1}
  };

  function automatic logic [19:0] encode(input logic [19:0] v);
    logic [5:0] r; logic [8:0] m; logic [3:0] a; logic pb; logic [19:0] w;
    {r, m, a, pb} = v;
    w = '0;
    w[0] = r[5]; w[1] = r[4]; w[2] = m[8]; w[3] = m[7]; w[4] = pb;
    for (int i = 0; i < 7; i++) w[5+i]  = m[6-i];
    for (int i = 0; i < 4; i++) w[12+i] = r[3-i];
    for (int i = 0; i < 4; i++) w[16+i] = a[3-i];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_fields(input string tag, input logic [19:0] v);
    chk(tag, {r_val, m_val, a_val, bypass}, {12'h0, v});
  endtask

  task automatic send_bits(input logic [19:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sdata = v[i]; sclk = 0;
      @(negedge clk); sclk = 1;
      @(negedge clk); sclk = 0;
      @(negedge clk);
    end
  endtask

  task automatic write_mode(input logic [7:0] v);
    ld_sel = 0; store_wr = 0; mode_wr = 1;
    @(negedge clk);
    send_bits({12'h0, v}, 8);
    mode_wr = 0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 fields after reset", {r_val, m_val, a_val, bypass}, 0);
    chk("R12 work after reset", work_word, 0);
    chk("R12 mode outs after reset", {pwr_down, cnt_load, sout, mode_err}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R6 R7 R3 R2: table of vectors
    for (int t = 0; t < 4; t++) begin
      fsel = 0;
      send_bits(encode(VEC[t]), 20);
      if (t > 0) chk_fields("R2 R3 secondary unchanged by serial load", VEC[t-1]);
      fsel = 1; @(negedge clk);
      chk_fields("R1 R6 R7 primary live fields", VEC[t]);
      store_wr = 1; @(negedge clk); store_wr = 0; @(negedge clk);
      fsel = 0; @(negedge clk);
      chk_fields("R3 secondary copy", VEC[t]);
    end
    fsel = 1; @(negedge clk);

    // R4 R2: mode staging does not touch primary, applies on fall
    ld_sel = 0; mode_wr = 1; @(negedge clk);
    send_bits(20'h08, 8);
    chk("R4 no change before fall", pwr_down, 0);
    chk_fields("R2 primary untouched by mode shift", VEC[3]);
    mode_wr = 0; @(negedge clk); @(negedge clk);
    chk("R4 power-down after fall", pwr_down, 1);
    enh_n = 1; @(negedge clk);
    chk("R5 enh high disables", {pwr_down, cnt_load, sout, mode_err}, 0);
    enh_n = 0; @(negedge clk);

    // R10: each source and request
    write_mode(8'h10);
    chk("R10 counter load", {pwr_down, cnt_load}, 2'b01);
    write_mode(8'h04);
    fb_div = 1; @(negedge clk);
    chk("R10 fb route high", {sout, mode_err}, 2'b10);
    fb_div = 0; @(negedge clk);
    chk("R10 fb route low", sout, 0);
    write_mode(8'h20);
    mod_sel = 1; @(negedge clk);
    chk("R10 modsel route", sout, 1);
    mod_sel = 0;
    write_mode(8'h40);
    ref_div = 1; @(negedge clk);
    chk("R10 ref route", sout, 1);

    // R11: priority and error
    write_mode(8'h64);
    fb_div = 0; mod_sel = 1; ref_div = 1; @(negedge clk);
    chk("R11 lowest source wins", {sout, mode_err}, 2'b01);
    write_mode(8'h42);
    chk("R11 work bit beats ref", {sout, mode_err}, 2'b01);
    enh_n = 1; @(negedge clk);
    chk("R5 error silenced", {sout, mode_err}, 0);
    enh_n = 0; mod_sel = 0; ref_div = 0;

    // R8: parallel loads
    nv_word = encode(VEC[0]); word_sel = 1; @(negedge clk); @(negedge clk);
    chk_fields("R8 R6 load on select rise", VEC[0]);
    ld_sel = 1; nv_word = encode(VEC[1]); @(negedge clk); @(negedge clk);
    chk_fields("R8 no load on ld rise", VEC[0]);
    ld_sel = 0; @(negedge clk); @(negedge clk);
    chk_fields("R8 load on ld fall", VEC[1]);

    // R9: shift out while shifting in
    write_mode(8'h02);
    ld_sel = 1; @(negedge clk);
    begin
      logic [19:0] old_w, new_w;
      int bad;
      old_w = encode(VEC[1]); new_w = encode(VEC[2]); bad = 0;
      for (int i = 0; i < 20; i++) begin
        if (sout !== old_w[i]) bad++;
        sdata = new_w[i]; sclk = 0;
        @(negedge clk); sclk = 1;
        @(negedge clk); sclk = 0;
        @(negedge clk);
      end
      chk("R9 serial out bit stream", bad, 0);
      chk("R9 first new bit visible", sout, new_w[0]);
      chk("R9 shifted-in word", work_word, new_w);
    end
    chk_fields("R9 R6 working fields after serial load", VEC[2]);

    // R12: reset mid-run
    rst_n = 0; @(negedge clk); @(negedge clk);
    rst_n = 1; ld_sel = 0; word_sel = 0; fsel = 1; @(negedge clk);
    chk("R12 mode cleared", {pwr_down, cnt_load, sout, mode_err}, 0);
    chk("R12 work cleared", work_word, 0);
    chk("R12 primary cleared", {r_val, m_val, a_val, bypass}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule